// File: doc/BRIEF.md
# Keypad Controller Command Front End

This block is the register and command layer of a keypad and GPIO controller that sits behind a byte-oriented serial target port such as I2C. The bit-level bus engine passes it three things: a strobe at the start of each transaction, written bytes, and requests for read bytes. The first byte written after a start strobe selects a command. Each later written byte is a parameter to that command, and parameters are numbered from zero. Read bytes return the register picked by the current command. The running byte index selects which byte of a wide register comes back.

The block holds the settings of the controller: configuration, active time, debounce time, keypad geometry, clock setup, and three 16-bit GPIO words for direction, pull selection and state mask. It also holds a sticky error register and an interrupt status byte. It checks every parameter. Faults are recorded in the error register, and an active-low interrupt is driven while any status bit is set. Once a command has taken its final parameter, it parks itself on the code 0xFF. Any stray extra byte in the same transaction is then reported instead of being applied a second time.

Top module: `kp_cmd_front`

## Requirements
- R1: After reset, the outputs are as follows. Configuration is 0x80, active time is 125 (0x7D), debounce is 3, keypad size is 0x33 and clock setup is 0x08. All three GPIO words are zero and the error register is zero. Status holds only the not-initialised flag (bit 4, value 0x10), so irq_n_o is low.
- R2: irq_n_o is low exactly when the status byte is non-zero. It follows status in the same clock cycle.
- R3: After a start strobe, the first written byte becomes the current command. Each later written byte is applied as parameter (position − 1). A new start strobe makes the next written byte a command again.
- R4: After its last parameter, a command parks the current command on 0xFF. A further written byte then sets error bit 0 (bad parameter) and status bit 3 (error).
- R5: An unrecognised command sets error bit 1 (unknown command) and status bit 3. This applies when it receives a parameter byte or when it is read. Such a read returns 0x00.
- R6: Command 0x83 with parameter 0xAA restores every register to its R1 value. Any other parameter sets the bad-parameter error and changes no register.
- R7: Reading with command 0x82 returns the status byte on read byte 0 and 0x00 on later bytes. Status is cleared after each such read unless bit 4 is set.
- R8: Command 0x81 stores its parameter as the configuration and clears the whole status byte. Reading with 0x92 returns the configuration's low nibble.
- R9: Command 0x90 always stores its parameter as the keypad size. The low nibble gives rows and the high nibble gives columns. Rows outside 3..12 or columns outside 3..8 set the bad-parameter error.
- R10: Command 0x8F stores debounce, and the value 0 sets the bad-parameter error. Command 0x93 stores clock setup, and low bits 01 or 10 set the bad-parameter error. Reading with 0x94 returns the clock setup with bits 1:0 replaced by 10. Command 0x8B stores active time with no check.
- R11: Commands 0x84 (pull), 0x85 (direction) and 0x86 (mask) take two parameters, low byte first. The GPIO output changes only when the high byte arrives. Reads with 0x87 (direction) and 0x88 (mask) return the low byte first, then the high byte.
- R12: Reading with 0x80 returns 0x00, then 0x04, then 0x00 for later bytes. Reading with 0x8C returns the error register. Reading with 0x8E returns 0x00.
- R13: rd_data_o takes the requested byte on the clock edge that samples rd_req_i and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| txn_start_i | input | 1 | Start-of-transaction strobe; clears the byte index and wins over a byte in the same cycle |
| wr_valid_i | input | 1 | A written byte is present |
| wr_data_i | input | 8 | Written byte |
| rd_req_i | input | 1 | Request for one read byte (ignored when wr_valid_i is high) |
| rd_data_o | output | 8 | Registered read byte |
| irq_n_o | output | 1 | Interrupt, active low |
| cfg_o | output | 8 | Configuration register |
| act_time_o | output | 8 | Active time register |
| debounce_o | output | 8 | Debounce register |
| key_size_o | output | 8 | Keypad geometry, columns in the high nibble and rows in the low nibble |
| clk_cfg_o | output | 8 | Clock setup register |
| gpio_dir_o | output | GPIO_W | GPIO direction word |
| gpio_pull_o | output | GPIO_W | GPIO pull selection word |
| gpio_mask_o | output | GPIO_W | GPIO state mask word |

## Verification
A wrong command register or byte index shows up one cycle later. Either a parameter lands in the wrong setting output, or a stray error flag pulls irq_n_o low. The bench compares every setting output and the interrupt line after each transaction. A status or error register that drifts from the expected value shows up on the next 0x82 or 0x8C read, which the bench issues often. The partial GPIO staging value is never visible except through a one-byte-early change of a GPIO output. The bench therefore samples between the low and the high byte.

// File: rtl/kp_cmd_pkg.sv
package kp_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_ID_RD   = 8'h80;
  localparam logic [7:0] OP_CFG_WR  = 8'h81;
  localparam logic [7:0] OP_STAT_RD = 8'h82;
  localparam logic [7:0] OP_RESET   = 8'h83;
  localparam logic [7:0] OP_PULL_WR = 8'h84;
  localparam logic [7:0] OP_DIR_WR  = 8'h85;
  localparam logic [7:0] OP_MASK_WR = 8'h86;
  localparam logic [7:0] OP_DIR_RD  = 8'h87;
  localparam logic [7:0] OP_MASK_RD = 8'h88;
  localparam logic [7:0] OP_ACT_WR  = 8'h8B;
  localparam logic [7:0] OP_ERR_RD  = 8'h8C;
  localparam logic [7:0] OP_ROT_RD  = 8'h8E;
  localparam logic [7:0] OP_DBN_WR  = 8'h8F;
  localparam logic [7:0] OP_SIZE_WR = 8'h90;
  localparam logic [7:0] OP_SIZE_RD = 8'h91;
  localparam logic [7:0] OP_CFG_RD  = 8'h92;
  localparam logic [7:0] OP_CLK_WR  = 8'h93;
  localparam logic [7:0] OP_CLK_RD  = 8'h94;
  localparam logic [7:0] OP_PARKED  = 8'hFF;

  localparam logic [7:0]  RESET_KEY = 8'hAA;
  localparam logic [15:0] ID_WORD   = 16'h0400;

  // status bits
  localparam int ST_ERR    = 3;
  localparam int ST_NOINIT = 4;
  // error bits
  localparam int ER_BADPAR = 0;
  localparam int ER_UNKCMD = 1;

  // defaults
  localparam logic [7:0] DEF_CFG  = 8'h80;
  localparam logic [7:0] DEF_STAT = 8'h10;
  localparam logic [7:0] DEF_ACT  = 8'd125;
  localparam logic [7:0] DEF_DBN  = 8'd3;
  localparam logic [7:0] DEF_SIZE = 8'h33;
  localparam logic [7:0] DEF_CLK  = 8'h08;

  // GPIO word slots
  localparam int GP_PULL  = 0;
  localparam int GP_DIR   = 1;
  localparam int GP_MASK  = 2;
  localparam int GP_WORDS = 3;
endpackage

// File: rtl/kp_byte_seq.sv
module kp_byte_seq
  import kp_cmd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       data_i,
  input  logic             park_i,
  output logic [7:0]       cmd_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_TOP = {IDX_W{1'b1}};

  logic [7:0]       cmd_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_inc;

  assign idx_inc = (idx_q == IDX_TOP) ? idx_q : idx_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmd_q <= OP_PARKED;
      idx_q <= '0;
    end else if (start_i) begin
      idx_q <= '0;
    end else if (wr_i) begin
      if (idx_q == '0) cmd_q <= data_i;
      else if (park_i) cmd_q <= OP_PARKED;
      idx_q <= idx_inc;
    end else if (rd_i) begin
      idx_q <= idx_inc;
    end
  end

  assign cmd_o = cmd_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/kp_param_check.sv
module kp_param_check #(
  parameter int ROW_MIN = 3,
  parameter int ROW_MAX = 12,
  parameter int COL_MIN = 3,
  parameter int COL_MAX = 8
) (
  input  logic [7:0] data_i,
  output logic       size_ok_o,
  output logic       dbn_ok_o,
  output logic       clk_ok_o
);
  logic [3:0] rows, cols;
  assign rows = data_i[3:0];
  assign cols = data_i[7:4];

  always_comb begin
    size_ok_o = (int'(rows) >= ROW_MIN) && (int'(rows) <= ROW_MAX) &&
                (int'(cols) >= COL_MIN) && (int'(cols) <= COL_MAX);
    dbn_ok_o  = (data_i != 8'h00);
    clk_ok_o  = (data_i[1] == data_i[0]);
  end
endmodule

// File: rtl/kp_read_mux.sv
module kp_read_mux
  import kp_cmd_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int GPIO_W = 16
) (
  input  logic [7:0]        cmd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        error_i,
  input  logic [7:0]        cfg_i,
  input  logic [7:0]        size_i,
  input  logic [7:0]        clk_i,
  input  logic [GPIO_W-1:0] dir_i,
  input  logic [GPIO_W-1:0] mask_i,
  output logic [7:0]        byte_o,
  output logic              known_o
);
  localparam int GB = GPIO_W / BYTE_W;
  localparam int IB = 16 / BYTE_W;

  always_comb begin
    byte_o  = 8'h00;
    known_o = 1'b1;
    unique case (cmd_i)
      OP_ID_RD: begin
        for (int b = 0; b < IB; b++)
          if (idx_i == IDX_W'(b)) byte_o = ID_WORD[b*BYTE_W +: BYTE_W];
      end
      OP_STAT_RD: byte_o = (idx_i == '0) ? status_i : 8'h00;
      OP_DIR_RD: begin
        for (int b = 0; b < GB; b++)
          if (idx_i == IDX_W'(b)) byte_o = dir_i[b*BYTE_W +: BYTE_W];
      end
      OP_MASK_RD: begin
        for (int b = 0; b < GB; b++)
          if (idx_i == IDX_W'(b)) byte_o = mask_i[b*BYTE_W +: BYTE_W];
      end
      OP_ERR_RD:  byte_o = error_i;
      OP_ROT_RD:  byte_o = 8'h00;
      OP_SIZE_RD: byte_o = size_i;
      OP_CFG_RD:  byte_o = {4'h0, cfg_i[3:0]};
      OP_CLK_RD:  byte_o = {clk_i[7:2], 2'b10};
      default:    known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/kp_reg_file.sv
module kp_reg_file
  import kp_cmd_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int GPIO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic [7:0]        cmd_i,
  input  logic [IDX_W-1:0]  pidx_i,
  input  logic [7:0]        data_i,
  input  logic              rd_i,
  input  logic              rd_known_i,
  input  logic              size_ok_i,
  input  logic              dbn_ok_i,
  input  logic              clk_ok_i,
  output logic              park_o,
  output logic [7:0]        status_o,
  output logic [7:0]        error_o,
  output logic              irq_n_o,
  output logic [7:0]        cfg_o,
  output logic [7:0]        act_o,
  output logic [7:0]        dbn_o,
  output logic [7:0]        size_o,
  output logic [7:0]        clk_o,
  output logic [GPIO_W-1:0] pull_o,
  output logic [GPIO_W-1:0] dir_o,
  output logic [GPIO_W-1:0] mask_o
);
  localparam int GB = GPIO_W / BYTE_W;

  logic [7:0] st_q, st_d, er_q, er_d;
  logic [7:0] cfg_q, cfg_d, act_q, act_d, dbn_q, dbn_d;
  logic [7:0] size_q, size_d, clk_q, clk_d;
  logic [GPIO_W-1:0] gp_q [GP_WORDS];
  logic [GPIO_W-1:0] gp_d [GP_WORDS];
  logic [GPIO_W-1:0] stage_q, stage_d, stage_full;
  logic [1:0] err_set;
  logic       load_def;
  logic       irq_n_q;
  int         gsel;

  always_comb begin
    unique case (cmd_i)
      OP_PULL_WR: gsel = GP_PULL;
      OP_DIR_WR:  gsel = GP_DIR;
      default:    gsel = GP_MASK;
    endcase
  end

  always_comb begin
    stage_full = stage_q;
    stage_full[(GB-1)*BYTE_W +: BYTE_W] = data_i;
  end

  always_comb begin
    st_d = st_q;  er_d = er_q;
    cfg_d = cfg_q; act_d = act_q; dbn_d = dbn_q;
    size_d = size_q; clk_d = clk_q; stage_d = stage_q;
    for (int w = 0; w < GP_WORDS; w++) gp_d[w] = gp_q[w];
    park_o = 1'b0; err_set = 2'b00; load_def = 1'b0;

    if (wr_i) begin
      unique case (cmd_i)
        OP_CFG_WR: begin
          cfg_d = data_i; st_d = 8'h00; park_o = 1'b1;
        end
        OP_RESET: begin
          park_o = 1'b1;
          if (data_i == RESET_KEY) load_def = 1'b1;
          else err_set[ER_BADPAR] = 1'b1;
        end
        OP_PULL_WR, OP_DIR_WR, OP_MASK_WR: begin
          for (int b = 0; b < GB - 1; b++)
            if (pidx_i == IDX_W'(b)) stage_d[b*BYTE_W +: BYTE_W] = data_i;
          if (pidx_i == IDX_W'(GB - 1)) begin
            gp_d[gsel] = stage_full;
            park_o = 1'b1;
          end
        end
        OP_ACT_WR: begin
          act_d = data_i; park_o = 1'b1;
        end
        OP_DBN_WR: begin
          dbn_d = data_i; park_o = 1'b1;
          if (!dbn_ok_i) err_set[ER_BADPAR] = 1'b1;
        end
        OP_SIZE_WR: begin
          size_d = data_i; park_o = 1'b1;
          if (!size_ok_i) err_set[ER_BADPAR] = 1'b1;
        end
        OP_CLK_WR: begin
          clk_d = data_i; park_o = 1'b1;
          if (!clk_ok_i) err_set[ER_BADPAR] = 1'b1;
        end
        OP_PARKED: err_set[ER_BADPAR] = 1'b1;
        default:   err_set[ER_UNKCMD] = 1'b1;
      endcase
    end else if (rd_i) begin
      if (!rd_known_i) err_set[ER_UNKCMD] = 1'b1;
      else if (cmd_i == OP_STAT_RD && !st_q[ST_NOINIT]) st_d = 8'h00;
    end

    if (load_def) begin
      st_d = DEF_STAT; er_d = 8'h00; cfg_d = DEF_CFG; act_d = DEF_ACT;
      dbn_d = DEF_DBN; size_d = DEF_SIZE; clk_d = DEF_CLK; stage_d = '0;
      for (int w = 0; w < GP_WORDS; w++) gp_d[w] = '0;
    end else if (|err_set) begin
      er_d = er_d | {6'b0, err_set};
      st_d[ST_ERR] = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q <= DEF_STAT; er_q <= 8'h00; cfg_q <= DEF_CFG; act_q <= DEF_ACT;
      dbn_q <= DEF_DBN; size_q <= DEF_SIZE; clk_q <= DEF_CLK;
      stage_q <= '0; irq_n_q <= 1'b0;
      for (int w = 0; w < GP_WORDS; w++) gp_q[w] <= '0;
    end else begin
      st_q <= st_d; er_q <= er_d; cfg_q <= cfg_d; act_q <= act_d;
      dbn_q <= dbn_d; size_q <= size_d; clk_q <= clk_d;
      stage_q <= stage_d; irq_n_q <= ~|st_d;
      for (int w = 0; w < GP_WORDS; w++) gp_q[w] <= gp_d[w];
    end
  end

  assign status_o = st_q;
  assign error_o  = er_q;
  assign irq_n_o  = irq_n_q;
  assign cfg_o    = cfg_q;
  assign act_o    = act_q;
  assign dbn_o    = dbn_q;
  assign size_o   = size_q;
  assign clk_o    = clk_q;
  assign pull_o   = gp_q[GP_PULL];
  assign dir_o    = gp_q[GP_DIR];
  assign mask_o   = gp_q[GP_MASK];
endmodule

// File: rtl/kp_cmd_front.sv
module kp_cmd_front
  import kp_cmd_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int GPIO_W  = 16,
  parameter int ROW_MIN = 3,
  parameter int ROW_MAX = 12,
  parameter int COL_MIN = 3,
  parameter int COL_MAX = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              txn_start_i,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_req_i,
  output logic [7:0]        rd_data_o,
  output logic              irq_n_o,
  output logic [7:0]        cfg_o,
  output logic [7:0]        act_time_o,
  output logic [7:0]        debounce_o,
  output logic [7:0]        key_size_o,
  output logic [7:0]        clk_cfg_o,
  output logic [GPIO_W-1:0] gpio_dir_o,
  output logic [GPIO_W-1:0] gpio_pull_o,
  output logic [GPIO_W-1:0] gpio_mask_o
);
  logic             wr_evt, rd_evt, param_evt, park;
  logic [7:0]       seq_cmd;
  logic [IDX_W-1:0] seq_idx, pidx;
  logic             size_ok, dbn_ok, clk_ok;
  logic [7:0]       rf_status, rf_error;
  logic [7:0]       rd_byte, rd_q;
  logic             rd_known;

  assign wr_evt    = wr_valid_i & ~txn_start_i;
  assign rd_evt    = rd_req_i & ~txn_start_i & ~wr_valid_i;
  assign param_evt = wr_evt & (seq_idx != '0);
  assign pidx      = seq_idx - 1'b1;

  kp_byte_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(txn_start_i),
    .wr_i(wr_evt), .rd_i(rd_evt), .data_i(wr_data_i), .park_i(park),
    .cmd_o(seq_cmd), .idx_o(seq_idx)
  );

  kp_param_check #(.ROW_MIN(ROW_MIN), .ROW_MAX(ROW_MAX),
                   .COL_MIN(COL_MIN), .COL_MAX(COL_MAX)) u_chk_par (
    .data_i(wr_data_i), .size_ok_o(size_ok), .dbn_ok_o(dbn_ok), .clk_ok_o(clk_ok)
  );

  kp_reg_file #(.IDX_W(IDX_W), .GPIO_W(GPIO_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_i(param_evt), .cmd_i(seq_cmd),
    .pidx_i(pidx), .data_i(wr_data_i), .rd_i(rd_evt), .rd_known_i(rd_known),
    .size_ok_i(size_ok), .dbn_ok_i(dbn_ok), .clk_ok_i(clk_ok),
    .park_o(park), .status_o(rf_status), .error_o(rf_error), .irq_n_o(irq_n_o),
    .cfg_o(cfg_o), .act_o(act_time_o), .dbn_o(debounce_o), .size_o(key_size_o),
    .clk_o(clk_cfg_o), .pull_o(gpio_pull_o), .dir_o(gpio_dir_o), .mask_o(gpio_mask_o)
  );

  kp_read_mux #(.IDX_W(IDX_W), .GPIO_W(GPIO_W)) u_rmux (
    .cmd_i(seq_cmd), .idx_i(seq_idx), .status_i(rf_status), .error_i(rf_error),
    .cfg_i(cfg_o), .size_i(key_size_o), .clk_i(clk_cfg_o),
    .dir_i(gpio_dir_o), .mask_i(gpio_mask_o), .byte_o(rd_byte), .known_o(rd_known)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_q <= 8'h00;
    else if (rd_evt) rd_q <= rd_byte;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/kp_cmd_front_chk.sv
module kp_cmd_front_chk
  import kp_cmd_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             txn_start_i,
  input logic             wr_valid_i,
  input logic [7:0]       wr_data_i,
  input logic             rd_req_i,
  input logic [7:0]       cmd_q,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       status_q,
  input logic [7:0]       error_q,
  input logic [7:0]       cfg_o,
  input logic             irq_n_o
);
  logic wr_head, wr_param;
  assign wr_head  = wr_valid_i && !txn_start_i && (idx_q == '0);
  assign wr_param = wr_valid_i && !txn_start_i && (idx_q != '0);

  a_r2_irq_level: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_n_o == (status_q == 8'h00));

  a_r3_head_loads_cmd: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_head |=> (cmd_q == $past(wr_data_i)));

  a_r3_start_clears_idx: assert property (@(posedge clk_i) disable iff (rst_i)
    txn_start_i |=> (idx_q == '0));

  a_r4_parked_byte_flags: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_param && cmd_q == OP_PARKED) |=> (error_q[ER_BADPAR] && status_q[ST_ERR]));

  a_r5_unknown_write_flags: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_param && cmd_q == OP_ID_RD) |=> (error_q[ER_UNKCMD] && status_q[ST_ERR]));

  a_r6_key_restores: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_param && cmd_q == OP_RESET && wr_data_i == RESET_KEY) |=>
      (cfg_o == DEF_CFG && status_q == DEF_STAT && error_q == 8'h00));

  a_r7_noinit_sticks: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_req_i && !wr_valid_i && !txn_start_i && cmd_q == OP_STAT_RD &&
     status_q[ST_NOINIT]) |=> status_q[ST_NOINIT]);
endmodule

bind kp_cmd_front kp_cmd_front_chk #(.IDX_W(IDX_W)) u_bound_chk (
  .clk_i(clk_i), .rst_i(rst_i), .txn_start_i(txn_start_i),
  .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .rd_req_i(rd_req_i),
  .cmd_q(seq_cmd), .idx_q(seq_idx), .status_q(rf_status), .error_q(rf_error),
  .cfg_o(cfg_o), .irq_n_o(irq_n_o)
);

// File: tb/kp_cmd_front_test.sv
module kp_cmd_front_test;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, wr_v = 1'b0, rd = 1'b0;
  logic [7:0]  wr_d = 8'h00;
  logic [7:0]  rd_data, cfg, act, dbn, ksize, ccfg;
  logic        irq_n;
  logic [15:0] gdir, gpull, gmask;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0]  m_cmd, m_st, m_err, m_cfg, m_act, m_dbn, m_size, m_clk, m_lo;
  logic [15:0] m_pull, m_dir, m_mask;
  int          m_idx;

  always #2.5 clk = ~clk;

  kp_cmd_front uut (
    .clk_i(clk), .rst_i(rst), .txn_start_i(start), .wr_valid_i(wr_v),
    .wr_data_i(wr_d), .rd_req_i(rd), .rd_data_o(rd_data), .irq_n_o(irq_n),
    .cfg_o(cfg), .act_time_o(act), .debounce_o(dbn), .key_size_o(ksize),
    .clk_cfg_o(ccfg), .gpio_dir_o(gdir), .gpio_pull_o(gpull), .gpio_mask_o(gmask)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic m_defaults;
    m_st = 8'h10; m_err = 8'h00; m_cfg = 8'h80; m_act = 8'd125; m_dbn = 8'd3;
    m_size = 8'h33; m_clk = 8'h08; m_lo = 8'h00;
    m_pull = '0; m_dir = '0; m_mask = '0;
  endtask

  task automatic m_wr(input logic [7:0] d);
    int p; bit park; logic [1:0] e; logic [3:0] r, c;
    if (m_idx == 0) m_cmd = d;
    else begin
      p = m_idx - 1; park = 0; e = 2'b00;
      case (m_cmd)
        8'h81: begin m_cfg = d; m_st = 8'h00; park = 1; end
        8'h83: begin park = 1; if (d == 8'hAA) m_defaults(); else e[0] = 1; end
        8'h84, 8'h85, 8'h86: begin
          if (p == 0) m_lo = d;
          else if (p == 1) begin
            park = 1;
            if (m_cmd == 8'h84) m_pull = {d, m_lo};
            else if (m_cmd == 8'h85) m_dir = {d, m_lo};
            else m_mask = {d, m_lo};
          end
        end
        8'h8B: begin m_act = d; park = 1; end
        8'h8F: begin m_dbn = d; park = 1; if (d == 0) e[0] = 1; end
        8'h90: begin
          m_size = d; park = 1; r = d[3:0]; c = d[7:4];
          if (r < 3 || r > 12 || c < 3 || c > 8) e[0] = 1;
        end
        8'h93: begin m_clk = d; park = 1; if (d[1] != d[0]) e[0] = 1; end
        8'hFF: e[0] = 1;
        default: e[1] = 1;
      endcase
      if (e != 0) begin m_err = m_err | {6'b0, e}; m_st = m_st | 8'h08; end
      if (park) m_cmd = 8'hFF;
    end
    if (m_idx != 15) m_idx++;
  endtask

  task automatic m_rd(output logic [7:0] exp);
    exp = 8'h00;
    case (m_cmd)
      8'h80: exp = (m_idx == 1) ? 8'h04 : 8'h00;
      8'h82: begin exp = (m_idx == 0) ? m_st : 8'h00; if (!m_st[4]) m_st = 8'h00; end
      8'h87: exp = (m_idx == 0) ? m_dir[7:0] : (m_idx == 1) ? m_dir[15:8] : 8'h00;
      8'h88: exp = (m_idx == 0) ? m_mask[7:0] : (m_idx == 1) ? m_mask[15:8] : 8'h00;
      8'h8C: exp = m_err;
      8'h8E: exp = 8'h00;
      8'h91: exp = m_size;
      8'h92: exp = {4'h0, m_cfg[3:0]};
      8'h94: exp = {m_clk[7:2], 2'b10};
      default: begin m_err = m_err | 8'h02; m_st = m_st | 8'h08; end
    endcase
    if (m_idx != 15) m_idx++;
  endtask

  task automatic do_start;
    start = 1'b1; @(negedge clk); start = 1'b0; m_idx = 0;
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr_v = 1'b1; wr_d = d; @(negedge clk); wr_v = 1'b0; m_wr(d);
  endtask

  task automatic do_rd(output logic [7:0] got, output logic [7:0] exp);
    rd = 1'b1; @(negedge clk); rd = 1'b0; got = rd_data; m_rd(exp);
  endtask

  task automatic cmd1(input logic [7:0] c, input logic [7:0] p);
    do_start(); do_wr(c); do_wr(p);
  endtask

  // read one byte of command c, compare to literal
  task automatic rd_lit(input string tag, input logic [7:0] c, input logic [7:0] lit);
    logic [7:0] g, x;
    do_start(); do_wr(c); do_start(); do_rd(g, x); chk(tag, g, lit);
  endtask

  task automatic ports_vs_model(input string tag);
    chk({tag, " cfg"}, cfg, m_cfg);
    chk({tag, " act"}, act, m_act);
    chk({tag, " dbn"}, dbn, m_dbn);
    chk({tag, " size"}, ksize, m_size);
    chk({tag, " clk"}, ccfg, m_clk);
    chk({tag, " pull"}, gpull, m_pull);
    chk({tag, " dir"}, gdir, m_dir);
    chk({tag, " mask"}, gmask, m_mask);
    chk({tag, " irq_n"}, irq_n, (m_st == 8'h00));
  endtask

  initial begin
    logic [7:0] g, x;
    logic [7:0] picks [12];
    picks = '{8'h81, 8'h83, 8'h84, 8'h85, 8'h86, 8'h8B, 8'h8F, 8'h90,
              8'h93, 8'h8B, 8'hC5, 8'h80};
    void'($urandom(32'd20240611));
    m_defaults(); m_cmd = 8'hFF; m_idx = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cfg", cfg, 8'h80);    chk("R1 act", act, 8'h7D);
    chk("R1 dbn", dbn, 8'h03);    chk("R1 size", ksize, 8'h33);
    chk("R1 clk", ccfg, 8'h08);   chk("R1 gpio", {gdir, gpull, gmask}, 48'h0);
    chk("R1 irq_n", irq_n, 1'b0);

    // R7 status read with not-initialised set: no clear; R13 registered data
    do_start(); do_wr(8'h82); do_start();
    do_rd(g, x); chk("R7 R13 status byte0", g, 8'h10);
    do_rd(g, x); chk("R7 status byte1", g, 8'h00);
    rd_lit("R7 noinit kept", 8'h82, 8'h10);
    chk("R2 irq while noinit", irq_n, 1'b0);

    // R12 ID
    do_start(); do_wr(8'h80); do_start();
    do_rd(g, x); chk("R12 id b0", g, 8'h00);
    do_rd(g, x); chk("R12 id b1", g, 8'h04);
    do_rd(g, x); chk("R12 id b2", g, 8'h00);
    rd_lit("R12 rotator", 8'h8E, 8'h00);

    // R8 config write clears status
    cmd1(8'h81, 8'h5A);
    chk("R8 cfg", cfg, 8'h5A);
    chk("R2 R8 irq released", irq_n, 1'b1);
    rd_lit("R8 cfg read", 8'h92, 8'h0A);

    // R4 parking
    do_start(); do_wr(8'h8B); do_wr(8'h40); do_wr(8'h41);
    chk("R4 act kept first", act, 8'h40);
    chk("R4 irq low", irq_n, 1'b0);
    rd_lit("R4 R12 error", 8'h8C, 8'h01);
    do_start(); do_wr(8'h82); do_start();
    do_rd(g, x); chk("R4 R7 status", g, 8'h08);
    do_rd(g, x); chk("R7 byte1 zero", g, 8'h00);
    chk("R7 cleared irq", irq_n, 1'b1);

    // R3 start strobe restarts command byte
    do_start(); do_wr(8'h8B); do_start(); do_wr(8'h8B); do_wr(8'h22);
    chk("R3 act", act, 8'h22);
    chk("R3 no error", irq_n, 1'b1);
    cmd1(8'h8F, 8'h05);
    chk("R3 dbn", dbn, 8'h05);

    // R5 unknown command
    cmd1(8'hC0, 8'h01);
    chk("R5 irq", irq_n, 1'b0);
    rd_lit("R5 error", 8'h8C, 8'h03);
    rd_lit("R5 unknown read", 8'hC1, 8'h00);
    rd_lit("R5 status", 8'h82, 8'h08);

    // R9 keypad size
    cmd1(8'h90, 8'h3C);
    chk("R9 size ok", ksize, 8'h3C); chk("R9 ok irq", irq_n, 1'b1);
    cmd1(8'h90, 8'h93);
    chk("R9 size stored", ksize, 8'h93); chk("R9 cols9 irq", irq_n, 1'b0);
    rd_lit("R9 clr", 8'h82, 8'h08);
    cmd1(8'h90, 8'h2D);
    chk("R9 bad irq", irq_n, 1'b0);
    rd_lit("R9 clr2", 8'h82, 8'h08);
    cmd1(8'h90, 8'h88);
    chk("R9 8x8 irq", irq_n, 1'b1);
    rd_lit("R9 size read", 8'h91, 8'h88);

    // R10 debounce and clock
    cmd1(8'h8F, 8'h00);
    chk("R10 dbn0", dbn, 8'h00); chk("R10 dbn0 irq", irq_n, 1'b0);
    rd_lit("R10 clr", 8'h82, 8'h08);
    cmd1(8'h93, 8'h01);
    chk("R10 clk01 irq", irq_n, 1'b0);
    rd_lit("R10 clr2", 8'h82, 8'h08);
    cmd1(8'h93, 8'hF7);
    chk("R10 clk11 irq", irq_n, 1'b1); chk("R10 clk", ccfg, 8'hF7);
    rd_lit("R10 clk read", 8'h94, 8'hF6);
    cmd1(8'h8B, 8'h00);
    chk("R10 act no check", irq_n, 1'b1);

    // R11 GPIO words
    do_start(); do_wr(8'h85); do_wr(8'h34);
    chk("R11 dir before high", gdir, 16'h0000);
    do_wr(8'h12);
    chk("R11 dir", gdir, 16'h1234);
    do_start(); do_wr(8'h87); do_start();
    do_rd(g, x); chk("R11 dir rd lo", g, 8'h34);
    do_rd(g, x); chk("R11 dir rd hi", g, 8'h12);
    do_start(); do_wr(8'h84); do_wr(8'hAB); do_wr(8'hCD);
    chk("R11 pull", gpull, 16'hCDAB);
    do_start(); do_wr(8'h86); do_wr(8'h0F); do_wr(8'hF0);
    do_start(); do_wr(8'h88); do_start();
    do_rd(g, x); chk("R11 mask rd lo", g, 8'h0F);
    do_rd(g, x); chk("R11 mask rd hi", g, 8'hF0);

    // R6 reset command
    cmd1(8'h83, 8'h55);
    chk("R6 bad key cfg", cfg, 8'h5A); chk("R6 bad key irq", irq_n, 1'b0);
    chk("R6 bad key dir", gdir, 16'h1234);
    cmd1(8'h83, 8'hAA);
    chk("R6 cfg", cfg, 8'h80); chk("R6 dbn", dbn, 8'h03);
    chk("R6 dir", gdir, 16'h0000); chk("R6 irq", irq_n, 1'b0);
    rd_lit("R6 status", 8'h82, 8'h10);
    rd_lit("R6 error", 8'h8C, 8'h00);

    // random transactions against the model
    for (int it = 0; it < 300; it++) begin
      logic [7:0] c, p;
      int n;
      c = picks[$urandom_range(0, 11)];
      n = $urandom_range(0, 3);
      do_start(); do_wr(c);
      for (int k = 0; k < n; k++) begin
        p = 8'($urandom());
        if (c == 8'h83 && $urandom_range(0, 1) == 1) p = 8'hAA;
        if (c == 8'h8F) p = 8'($urandom_range(0, 3));
        if (c == 8'h90) p = {4'($urandom_range(2, 9)), 4'($urandom_range(2, 13))};
        do_wr(p);
      end
      ports_vs_model("R11 R3 rnd");
      if (it % 6 == 5) begin
        do_start(); do_wr(8'h8C); do_start(); do_rd(g, x); chk("R12 R5 rnd error", g, x);
        do_start(); do_wr(8'h82); do_start(); do_rd(g, x); chk("R7 rnd status", g, x);
        chk("R2 rnd irq", irq_n, (m_st == 8'h00));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule